// File: doc/BRIEF.md
# SPI Chip Select Controller

This block drives the four active-low peripheral select lines of an SPI master and tells the serial shift engine which of four per-slave configuration sets applies to the current transfer. The 4-bit select code comes from one of two places. In fixed selection it comes from a static register field. In variable selection it comes from the upper bits of each 32-bit transmit word, so a stream of words can address different slaves without any software action between them.

The lines can be driven in two ways. In direct mode at most one line goes low: the lowest-numbered zero bit of the code. In decode mode the raw code is placed on the lines for an external 4-to-16 decoder. Because the idle pattern is all ones, only codes 0x0 to 0xE name a peripheral in decode mode. Each configuration set serves one line in direct mode and four consecutive decoded codes in decode mode. The selected set supplies a bits-per-transfer value, which is kept between 8 and 16.

The code is captured when a transfer starts. It holds until the transfer ends. An option can keep the lines asserted between transfers for as long as the same slave is being addressed.

Top module: `spi_chipsel`

## Requirements
- R1: While reset is asserted and right after it is released, `npcs` is 4'hF and `xferGo` is 0.
- R2: When `varSel` is 0 the code is `modeCode`. When `varSel` is 1 the code is `txWord[19:16]`, taken from the word presented with `txValid` in the same cycle as `xferStart`, or else from the last word accepted with `txValid`.
- R3: In direct mode (`decodeEn`=0) a valid code drives low only the line at the lowest zero bit position p of the code, and `cfgIdx` equals p.
- R4: In decode mode (`decodeEn`=1) a valid code appears unchanged on `npcs`, and `cfgIdx` equals code[3:2].
- R5: Code 4'hF selects nothing in either mode. A start with that code gives no `xferGo` pulse, and the lines stay at 4'hF.
- R6: After a start with a valid code, the new line pattern and a one-cycle `xferGo` pulse appear in the next cycle. When `holdCs` is 0, the lines return to 4'hF in the cycle after `xferDone`.
- R7: With `holdCs`=1, the lines stay asserted after `xferDone`. A following start that maps to the same line pattern keeps them low and gives `xferGo` in the next cycle.
- R8: With the lines held, a start that maps to a different pattern gives one cycle of 4'hF. The new pattern and `xferGo` then appear in the cycle after that.
- R9: Held lines are released in the cycle after `xferDone` if the transfer's word had the last-transfer flag `txWord[24]` set (variable mode only). They are also released in the cycle after `holdCs` reads 0 while held.
- R10: While a transfer is active, changes to `modeCode`, `decodeEn` or `txWord`, and extra `xferStart` pulses, leave `npcs` and `cfgIdx` unchanged and produce no `xferGo`.
- R11: `bitsPerXfer` is the value of set `cfgIdx`, taken from `cfgBits[5k+4:5k]` for set k. Values below 8 are raised to 8 and values above 16 are lowered to 16.
- R12: `modeFaultEn` is `faultDetEn` when `holdCs` is 0, and is always 0 when `holdCs` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| varSel | input | 1 | 1 = code taken from each transmit word |
| decodeEn | input | 1 | 1 = raw code placed on the lines for an external decoder |
| modeCode | input | 4 | Code used in fixed selection |
| holdCs | input | 1 | Keep lines asserted after a transfer |
| faultDetEn | input | 1 | Mode fault detection requested |
| txWord | input | 32 | Transmit word: data [15:0], code [19:16], last flag [24] |
| txValid | input | 1 | Transmit word strobe |
| cfgBits | input | 20 | Four packed 5-bit bits-per-transfer values |
| xferStart | input | 1 | Shift engine requests a transfer |
| xferDone | input | 1 | Shift engine finished a transfer |
| npcs | output | 4 | Active-low chip select lines |
| cfgIdx | output | 2 | Selected configuration set |
| bitsPerXfer | output | 5 | Bits per transfer of the selected set |
| modeFaultEn | output | 1 | Mode fault detection enable |
| xferGo | output | 1 | One-cycle pulse: transfer accepted |

## Verification
On every cycle the assertions check these invariants: no more than one line is low in direct mode, the decoded set index matches the upper code bits, the lines stay still while a transfer is active or held, the lines return to idle after a transfer without hold, the go pulse appears only while a slave is selected, the bit count stays in range, and fault detection is off while hold is set. Only the bench scenarios can show that the right line is chosen for each code. The sweep covers all sixteen codes in both output modes and both code sources. The scenarios also show the one-cycle release when a held slave changes, and the release caused by the last-transfer flag.

// File: rtl/spi_chipsel_pkg.sv
package spi_chipsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_HOLD,
    ST_SWAP
  } csState_t;

  typedef struct packed {
    logic latch;  // capture candidate code, lines and set index
    logic drive;  // put captured pattern on the lines
    logic go;     // transfer accepted pulse
  } csStrobe_t;
endpackage

// File: rtl/spi_chipsel_dp.sv
module spi_chipsel_dp
  import spi_chipsel_pkg::*;
#(
  parameter int CS_W     = 4,
  parameter int WORD_W   = 32,
  parameter int CODE_LSB = 16,
  parameter int LAST_BIT = 24,
  parameter int BITS_W   = 5,
  parameter int MIN_BITS = 8,
  parameter int MAX_BITS = 16,
  localparam int IDX_W   = $clog2(CS_W),
  localparam int NSETS   = CS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    varSel,
  input  logic                    decodeEn,
  input  logic [CS_W-1:0]         modeCode,
  input  logic [WORD_W-1:0]       txWord,
  input  logic                    txValid,
  input  logic [NSETS*BITS_W-1:0] cfgBits,
  input  csStrobe_t               stb,
  output logic                    candValid,
  output logic                    candDiffers,
  output logic                    lastQ,
  output logic                    decQ,
  output logic [CS_W-1:0]         npcs,
  output logic [IDX_W-1:0]        cfgIdx,
  output logic [BITS_W-1:0]       bitsPerXfer
);
  logic [WORD_W-1:0] txHeld;
  logic [WORD_W-1:0] srcWord;
  logic [CS_W-1:0]   candCode;
  logic              candLast;
  logic [CS_W-1:0]   candNpcs;
  logic [IDX_W-1:0]  candIdx;
  logic [CS_W-1:0]   dirNpcs;
  logic [IDX_W-1:0]  dirIdx;
  logic              dirHit;
  logic [CS_W-1:0]   heldNpcs;
  logic [IDX_W-1:0]  idxQ;
  logic [BITS_W-1:0] cfgSet [NSETS];
  logic [BITS_W-1:0] selBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txHeld <= '0;
    else if (txValid) txHeld <= txWord;
  end

  // same-cycle word bypasses the holding register
  assign srcWord  = txValid ? txWord : txHeld;
  assign candCode = varSel ? srcWord[CODE_LSB +: CS_W] : modeCode;
  assign candLast = varSel & srcWord[LAST_BIT];

  // direct mode: lowest zero bit wins
  always_comb begin
    dirHit = 1'b0;
    dirIdx = '0;
    for (int i = CS_W - 1; i >= 0; i--) begin
      if (!candCode[i]) begin
        dirHit = 1'b1;
        dirIdx = IDX_W'(i);
      end
    end
    dirNpcs = ~(CS_W'(dirHit) << dirIdx);
  end

  always_comb begin
    if (decodeEn) begin
      candNpcs  = candCode;
      candIdx   = candCode[CS_W-1 -: IDX_W];
      candValid = (candCode != {CS_W{1'b1}});
    end else begin
      candNpcs  = dirNpcs;
      candIdx   = dirIdx;
      candValid = dirHit;
    end
  end

  assign candDiffers = (candNpcs != heldNpcs);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldNpcs <= '1;
      idxQ     <= '0;
      lastQ    <= 1'b0;
      decQ     <= 1'b0;
    end else if (stb.latch) begin
      heldNpcs <= candNpcs;
      idxQ     <= candIdx;
      lastQ    <= candLast;
      decQ     <= decodeEn;
    end
  end

  assign npcs   = stb.drive ? heldNpcs : '1;
  assign cfgIdx = idxQ;

  for (genvar k = 0; k < NSETS; k++) begin : g_sets
    assign cfgSet[k] = cfgBits[k*BITS_W +: BITS_W];
  end

  assign selBits = cfgSet[idxQ];

  always_comb begin
    if (selBits < BITS_W'(MIN_BITS))      bitsPerXfer = BITS_W'(MIN_BITS);
    else if (selBits > BITS_W'(MAX_BITS)) bitsPerXfer = BITS_W'(MAX_BITS);
    else                                  bitsPerXfer = selBits;
  end
endmodule

// File: rtl/spi_chipsel_ctrl.sv
module spi_chipsel_ctrl
  import spi_chipsel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      xferStart,
  input  logic      xferDone,
  input  logic      holdCs,
  input  logic      candValid,
  input  logic      candDiffers,
  input  logic      lastQ,
  output csStrobe_t stb
);
  csState_t state, stateNext;
  logic     goQ, goNext, latchNext;

  always_comb begin
    stateNext = state;
    goNext    = 1'b0;
    latchNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (xferStart && candValid) begin
          latchNext = 1'b1;
          goNext    = 1'b1;
          stateNext = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (xferDone) stateNext = (holdCs && !lastQ) ? ST_HOLD : ST_IDLE;
      end
      ST_HOLD: begin
        if (!holdCs) begin
          stateNext = ST_IDLE;
        end else if (xferStart) begin
          if (!candValid) begin
            stateNext = ST_IDLE;
          end else if (candDiffers) begin
            latchNext = 1'b1;
            stateNext = ST_SWAP;
          end else begin
            latchNext = 1'b1;
            goNext    = 1'b1;
            stateNext = ST_ACTIVE;
          end
        end
      end
      ST_SWAP: begin
        goNext    = 1'b1;
        stateNext = ST_ACTIVE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      goQ   <= 1'b0;
    end else begin
      state <= stateNext;
      goQ   <= goNext;
    end
  end

  assign stb.latch = latchNext;
  assign stb.drive = (state == ST_ACTIVE) || (state == ST_HOLD);
  assign stb.go    = goQ;
endmodule

// File: rtl/spi_chipsel.sv
module spi_chipsel
  import spi_chipsel_pkg::*;
#(
  parameter int CS_W     = 4,
  parameter int WORD_W   = 32,
  parameter int BITS_W   = 5,
  localparam int IDX_W   = $clog2(CS_W)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   varSel,
  input  logic                   decodeEn,
  input  logic [CS_W-1:0]        modeCode,
  input  logic                   holdCs,
  input  logic                   faultDetEn,
  input  logic [WORD_W-1:0]      txWord,
  input  logic                   txValid,
  input  logic [CS_W*BITS_W-1:0] cfgBits,
  input  logic                   xferStart,
  input  logic                   xferDone,
  output logic [CS_W-1:0]        npcs,
  output logic [IDX_W-1:0]       cfgIdx,
  output logic [BITS_W-1:0]      bitsPerXfer,
  output logic                   modeFaultEn,
  output logic                   xferGo
);
  csStrobe_t stb;
  logic      candValid, candDiffers, lastQ, decQ;

  spi_chipsel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .xferStart(xferStart), .xferDone(xferDone), .holdCs(holdCs),
    .candValid(candValid), .candDiffers(candDiffers), .lastQ(lastQ),
    .stb(stb)
  );

  spi_chipsel_dp #(.CS_W(CS_W), .WORD_W(WORD_W), .BITS_W(BITS_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .varSel(varSel), .decodeEn(decodeEn), .modeCode(modeCode),
    .txWord(txWord), .txValid(txValid), .cfgBits(cfgBits),
    .stb(stb),
    .candValid(candValid), .candDiffers(candDiffers), .lastQ(lastQ), .decQ(decQ),
    .npcs(npcs), .cfgIdx(cfgIdx), .bitsPerXfer(bitsPerXfer)
  );

  assign xferGo      = stb.go;
  assign modeFaultEn = faultDetEn & ~holdCs;
endmodule

// File: rtl/spi_chipsel_chk.sv
module spi_chipsel_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] npcs,
  input logic [1:0] cfgIdx,
  input logic [4:0] bitsPerXfer,
  input logic       holdCs,
  input logic       modeFaultEn,
  input logic       xferStart,
  input logic       xferDone,
  input logic       xferGo,
  input logic       decQ
);
  // R3
  one_line_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decQ |-> ($countones(~npcs) <= 1));

  // R4
  decode_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decQ && npcs != 4'hF) |-> (cfgIdx == npcs[3:2]));

  // R6
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !holdCs && npcs != 4'hF) |=> (npcs == 4'hF));

  // R6
  go_with_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferGo |-> (npcs != 4'hF));

  // R10
  lines_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (npcs != 4'hF && !xferDone && !xferStart && holdCs && $stable(holdCs)) |=> $stable(npcs));

  // R11
  bits_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitsPerXfer >= 5'd8) && (bitsPerXfer <= 5'd16));

  // R12
  fault_off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCs |-> !modeFaultEn);
endmodule

bind spi_chipsel spi_chipsel_chk u_chk (
  .clk(clk), .rstN(rstN), .npcs(npcs), .cfgIdx(cfgIdx), .bitsPerXfer(bitsPerXfer),
  .holdCs(holdCs), .modeFaultEn(modeFaultEn), .xferStart(xferStart),
  .xferDone(xferDone), .xferGo(xferGo), .decQ(decQ)
);

// File: tb/sim_spi_chipsel.sv
module sim_spi_chipsel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        varSel = 1'b0, decodeEn = 1'b0, holdCs = 1'b0, faultDetEn = 1'b0;
  logic [3:0]  modeCode = 4'hF;
  logic [31:0] txWord = '0;
  logic        txValid = 1'b0, xferStart = 1'b0, xferDone = 1'b0;
  logic [19:0] cfgBits;
  logic [3:0]  npcs;
  logic [1:0]  cfgIdx;
  logic [4:0]  bitsPerXfer;
  logic        modeFaultEn, xferGo;
  int          nChecks = 0, nFail = 0;
  logic [4:0]  setVal [4];

  spi_chipsel u0 (
    .clk(clk), .rstN(rstN), .varSel(varSel), .decodeEn(decodeEn), .modeCode(modeCode),
    .holdCs(holdCs), .faultDetEn(faultDetEn), .txWord(txWord), .txValid(txValid),
    .cfgBits(cfgBits), .xferStart(xferStart), .xferDone(xferDone),
    .npcs(npcs), .cfgIdx(cfgIdx), .bitsPerXfer(bitsPerXfer),
    .modeFaultEn(modeFaultEn), .xferGo(xferGo)
  );

  always #5 clk = ~clk;

  initial begin
    setVal[0] = 5'd5; setVal[1] = 5'd9; setVal[2] = 5'd12; setVal[3] = 5'd20;
  end
  assign cfgBits = {setVal[3], setVal[2], setVal[1], setVal[0]};

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic validCode(input logic [3:0] c);
    return c != 4'hF;
  endfunction

  function automatic int lowZero(input logic [3:0] c);
    for (int i = 0; i < 4; i++) if (!c[i]) return i;
    return 0;
  endfunction

  function automatic logic [3:0] expLines(input logic [3:0] c, input logic dec);
    if (dec) return c;
    return 4'hF ^ (4'h1 << lowZero(c));
  endfunction

  function automatic int expIdx(input logic [3:0] c, input logic dec);
    return dec ? int'(c) / 4 : lowZero(c);
  endfunction

  function automatic int expBits(input int idx);
    int v = int'(setVal[idx]);
    if (v < 8) return 8;
    if (v > 16) return 16;
    return v;
  endfunction

  function automatic logic [31:0] mkWord(input logic [3:0] c, input logic last);
    return {7'd0, last, 4'd0, c, 16'hA5C3};
  endfunction

  // one transfer with hold off; caller has set varSel/decodeEn
  task automatic runXfer(input logic [3:0] c, input logic preload);
    if (varSel) begin
      modeCode = ~c;
      if (preload) begin
        txWord = mkWord(c, 1'b0); txValid = 1'b1;
        @(negedge clk);
        txValid = 1'b0; txWord = mkWord(c ^ 4'h6, 1'b0);
      end else begin
        txWord = mkWord(c, 1'b0); txValid = 1'b1;
      end
    end else begin
      modeCode = c;
      txWord = mkWord(c ^ 4'h5, 1'b0);
    end
    xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0; txValid = 1'b0;
    if (validCode(c)) begin
      check(varSel ? "R2 lines" : (decodeEn ? "R4 lines" : "R3 lines"),
            int'(npcs), int'(expLines(c, decodeEn)));
      check(decodeEn ? "R4 set" : "R3 set", int'(cfgIdx), expIdx(c, decodeEn));
      check("R11 bits", int'(bitsPerXfer), expBits(expIdx(c, decodeEn)));
      check("R6 go", int'(xferGo), 1);
      xferDone = 1'b1;
      @(negedge clk);
      xferDone = 1'b0;
      check("R6 release", int'(npcs), 15);
      check("R6 go pulse", int'(xferGo), 0);
    end else begin
      check("R5 no go", int'(xferGo), 0);
      check("R5 idle lines", int'(npcs), 15);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 lines", int'(npcs), 15);
    check("R1 go", int'(xferGo), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(npcs), 15);

    // full sweep: sources x output modes x codes
    for (int v = 0; v < 2; v++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 16; c++) begin
          varSel = v[0]; decodeEn = d[0];
          runXfer(4'(c), c[0] == 1'b0);
        end

    // R12 fault detection gating
    for (int f = 0; f < 2; f++)
      for (int h = 0; h < 2; h++) begin
        faultDetEn = f[0]; holdCs = h[0];
        #1;
        check("R12 fault en", int'(modeFaultEn), (f == 1 && h == 0) ? 1 : 0);
      end
    faultDetEn = 1'b0; holdCs = 1'b0;
    @(negedge clk);

    // R10 changes during an active transfer
    varSel = 1'b0; decodeEn = 1'b0; modeCode = 4'b1011;
    xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0;
    check("R3 line2", int'(npcs), 4'b1011);
    modeCode = 4'h0; decodeEn = 1'b1; txWord = mkWord(4'h1, 1'b1); xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0;
    check("R10 lines kept", int'(npcs), 4'b1011);
    check("R10 set kept", int'(cfgIdx), 2);
    check("R10 no go", int'(xferGo), 0);
    @(negedge clk);
    check("R10 lines kept later", int'(npcs), 4'b1011);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0; decodeEn = 1'b0;
    check("R6 release after R10", int'(npcs), 15);

    // R7 hold with same slave
    holdCs = 1'b1; modeCode = 4'hD;
    xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0;
    check("R7 first", int'(npcs), 4'b1101);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check("R7 held", int'(npcs), 4'b1101);
    @(negedge clk);
    check("R7 still held", int'(npcs), 4'b1101);
    xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0;
    check("R7 same go", int'(xferGo), 1);
    check("R7 same lines", int'(npcs), 4'b1101);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check("R7 held again", int'(npcs), 4'b1101);
    holdCs = 1'b0;
    @(negedge clk);
    check("R9 hold cleared", int'(npcs), 15);

    // R8 different slave while held
    holdCs = 1'b1; modeCode = 4'hE;
    xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0;
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check("R7 line0 held", int'(npcs), 4'b1110);
    modeCode = 4'h7; xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0;
    check("R8 gap lines", int'(npcs), 15);
    check("R8 gap no go", int'(xferGo), 0);
    @(negedge clk);
    check("R8 new lines", int'(npcs), 4'b0111);
    check("R8 new go", int'(xferGo), 1);
    check("R8 new set", int'(cfgIdx), 3);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0; holdCs = 1'b0;
    @(negedge clk);
    check("R9 released", int'(npcs), 15);

    // R9 last-transfer flag overrides hold
    holdCs = 1'b1; varSel = 1'b1; decodeEn = 1'b1;
    txWord = mkWord(4'h3, 1'b1); txValid = 1'b1; xferStart = 1'b1;
    @(negedge clk);
    txValid = 1'b0; xferStart = 1'b0;
    check("R4 raw code", int'(npcs), 3);
    check("R11 set0 clamp", int'(bitsPerXfer), 8);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check("R9 last flag release", int'(npcs), 15);
    holdCs = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule